// File: doc/BRIEF.md
# PLL Programming Sequencer

This block drives the three control images of a display PHY PLL through its bring-up order without software pacing each step. One start pulse latches the operands (config-clock frequency, high-speed range code, feedback multiplier, input divider, VCO and proportional control codes). The block then walks a fixed sequence:

- select the clock-generation source alone;
- pulse shadow-clear while keeping that selection;
- drop shadow-clear;
- write the range, divider and charge-pump images and enable the reference clock;
- wait a settle interval;
- raise update-PLL for a minimum width, then clear it.

A power-off command zeroes all three images and the reference-clock enable at any time.

All step lengths are parameters counted in system-clock cycles. The settle and update intervals are expressed in reference-clock cycles and scaled by the ratio of system clock to reference clock. The block has no data stream. Every pin is a plain control or status level, so no valid/ready back-pressure applies. Operands must be valid in the cycle the start pulse is sampled.

Top module: `pllprog_seq`

## Requirements
- R1: After reset, all three images are zero, the reference enable is low, and busy and done are low.
- R2: A start pulse sampled while idle makes the next-cycle control image exactly 0x40 (select field [7:6] = 1, clock generation, nothing else set). In that same cycle the reference enable is low and busy is high. The image stays at 0x40 for SEL_CYC cycles.
- R3: Shadow-clear (control bit 18) is then set together with select = 1, giving 0x40040, for SHC_CYC cycles. The image then returns to 0x40 for exactly one cycle.
- R4: The program step writes all three images in one cycle:
  - Control image: [5:0] = ((config MHz − 17) × 4) mod 64, [7:6] = 1, [14:8] = HS range code, all other bits 0.
  - Divider image: [9:0] = M − 2, [13:10] = N − 1, [19:14] = VCO code, [25:20] = proportional code, [31:26] = 0.
  - Auxiliary image: [1:0] = 1, [8:2] = 0x10, bit 9 = 0, giving 0x41.
  - The reference enable rises in that same cycle.
- R5: Update-PLL (control bit 17) is set only after the reference enable has been high for SETTLE_REF × REF_RATIO cycles.
- R6: Update-PLL stays set for UPD_REF × REF_RATIO cycles and is then cleared, leaving the program-step control image.
- R7: Done is a one-cycle pulse in the cycle after update-PLL is cleared. Busy is high from the cycle after start until done, and low while done is high.
- R8: A start pulse while busy is ignored: the sequence timing is unchanged and no second run follows.
- R9: Operands are captured at start; changing the operand inputs during a run has no effect on the written images.
- R10: Power-off zeroes all three images and the reference enable in the next cycle. It aborts a run without a done pulse and wins over a simultaneous start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; begins a programming run when idle |
| pwr_off_i | input | 1 | Power-off command; zeroes images and reference enable |
| cfgclk_mhz_i | input | 8 | Configuration clock frequency in MHz |
| hs_range_i | input | 7 | High-speed frequency range code |
| mult_i | input | 10 | Feedback multiplier M |
| div_i | input | 5 | Input divider N (1 to 16) |
| vco_i | input | 6 | VCO control code |
| prop_i | input | 6 | Proportional control code |
| ctrl_o | output | 32 | Control register image |
| divr_o | output | 32 | Divider register image |
| aux_o | output | 32 | Auxiliary (charge-pump) register image |
| ref_en_o | output | 1 | Reference clock enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are a power-off landing inside the settle window and a second start arriving mid-run. Both must leave no trace beyond what R8 and R10 allow. The stimulus counts cycles from the start pulse and times the second start in the shadow-clear phase and the power-off inside the settle wait. The scoreboard holds the full ordered list of image changes, each with its cycle gap from the previous change. Any extra or missing transition from the aborted or ignored run therefore shows up as a mismatch or an unexpected change.

// File: rtl/pllprog_pkg.sv
package pllprog_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_SHC,
    S_HOLD,
    S_SETTLE,
    S_UPD,
    S_FIN
  } seq_state_e;

  localparam logic [1:0] CLKSEL_GEN = 2'd1;
  localparam int         SHC_BIT    = 18;
  localparam int         UPD_BIT    = 17;
  localparam logic [31:0] GEN_WORD  = 32'h0000_0040;

  // Latched and pre-encoded operands
  typedef struct packed {
    logic [5:0] cfg_rng;
    logic [6:0] hs_rng;
    logic [9:0] m_code;
    logic [3:0] n_code;
    logic [5:0] vco;
    logic [5:0] prop;
  } pll_op_t;

  // Config-clock range: (MHz - 17) * 4, truncated to the 6-bit field
  function automatic logic [5:0] cfg_range(input logic [7:0] mhz);
    return 6'((mhz - 8'd17) * 8'd4);
  endfunction

endpackage

// File: rtl/pllprog_timer.sv
module pllprog_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (restart)    count <= '0;
    else if (count != CMAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/pllprog_fsm.sv
module pllprog_fsm
  import pllprog_pkg::*;
#(
  parameter int SEL_CYC    = 4,
  parameter int SHC_CYC    = 2,
  parameter int SETTLE_CYC = 20,
  parameter int UPD_CYC    = 8,
  parameter int CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pwr_off,
  input  logic [CW-1:0] count,
  output logic          restart,
  output logic          cap,
  output logic          ld_sel,
  output logic          ld_shc,
  output logic          ld_gen,
  output logic          ld_prog,
  output logic          set_upd,
  output logic          clr_upd,
  output logic          ld_zero,
  output logic          busy,
  output logic          done
);
  localparam logic [CW-1:0] SEL_LAST    = CW'(SEL_CYC - 1);
  localparam logic [CW-1:0] SHC_LAST    = CW'(SHC_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] UPD_LAST    = CW'(UPD_CYC - 1);

  seq_state_e st, nxt;
  logic       fin;

  always_comb begin
    nxt     = st;
    restart = 1'b0;
    cap     = 1'b0;
    ld_sel  = 1'b0;
    ld_shc  = 1'b0;
    ld_gen  = 1'b0;
    ld_prog = 1'b0;
    set_upd = 1'b0;
    clr_upd = 1'b0;
    ld_zero = 1'b0;
    fin     = 1'b0;
    if (pwr_off) begin
      nxt     = S_IDLE;
      ld_zero = 1'b1;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          nxt = S_SEL; cap = 1'b1; ld_sel = 1'b1; restart = 1'b1;
        end
        S_SEL: if (count == SEL_LAST) begin
          nxt = S_SHC; ld_shc = 1'b1; restart = 1'b1;
        end
        S_SHC: if (count == SHC_LAST) begin
          nxt = S_HOLD; ld_gen = 1'b1;
        end
        S_HOLD: begin
          nxt = S_SETTLE; ld_prog = 1'b1; restart = 1'b1;
        end
        S_SETTLE: if (count == SETTLE_LAST) begin
          nxt = S_UPD; set_upd = 1'b1; restart = 1'b1;
        end
        S_UPD: if (count == UPD_LAST) begin
          nxt = S_FIN; clr_upd = 1'b1;
        end
        S_FIN: begin
          nxt = S_IDLE; fin = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      done <= fin;
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/pllprog_image.sv
module pllprog_image
  import pllprog_pkg::*;
#(
  parameter logic [1:0] GMP_VAL     = 2'd1,
  parameter logic [6:0] CPBIAS_VAL  = 7'h10,
  parameter logic       SHADOW_FLAG = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pll_op_t     op_in,
  input  logic        cap,
  input  logic        ld_sel,
  input  logic        ld_shc,
  input  logic        ld_gen,
  input  logic        ld_prog,
  input  logic        set_upd,
  input  logic        clr_upd,
  input  logic        ld_zero,
  output logic [31:0] ctrl,
  output logic [31:0] divr,
  output logic [31:0] aux,
  output logic        ref_en
);
  pll_op_t     snap;
  logic [31:0] prog_ctrl, prog_div, prog_aux;

  // [19] external clock, [18] shadow clear, [17] update stay low here
  assign prog_ctrl = {12'd0, 1'b0, 1'b0, 1'b0, 2'b00,
                      snap.hs_rng, CLKSEL_GEN, snap.cfg_rng};
  // Integral control field is written as zero
  assign prog_div  = {6'd0, snap.prop, snap.vco, snap.n_code, snap.m_code};
  assign prog_aux  = {22'd0, SHADOW_FLAG, CPBIAS_VAL, GMP_VAL};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      ctrl   <= '0;
      divr   <= '0;
      aux    <= '0;
      ref_en <= 1'b0;
    end else if (ld_zero) begin
      ctrl   <= '0;
      divr   <= '0;
      aux    <= '0;
      ref_en <= 1'b0;
    end else begin
      if (cap) snap <= op_in;
      if (ld_sel) begin
        ctrl   <= GEN_WORD;
        ref_en <= 1'b0;
      end
      if (ld_shc) ctrl <= GEN_WORD | (32'd1 << SHC_BIT);
      if (ld_gen) ctrl <= GEN_WORD;
      if (ld_prog) begin
        ctrl   <= prog_ctrl;
        divr   <= prog_div;
        aux    <= prog_aux;
        ref_en <= 1'b1;
      end
      if (set_upd) ctrl[UPD_BIT] <= 1'b1;
      if (clr_upd) ctrl[UPD_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/pllprog_seq.sv
module pllprog_seq
  import pllprog_pkg::*;
#(
  parameter int SEL_CYC    = 4,
  parameter int SHC_CYC    = 2,
  parameter int SETTLE_REF = 10,
  parameter int UPD_REF    = 4,
  parameter int REF_RATIO  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        pwr_off_i,
  input  logic [7:0]  cfgclk_mhz_i,
  input  logic [6:0]  hs_range_i,
  input  logic [9:0]  mult_i,
  input  logic [4:0]  div_i,
  input  logic [5:0]  vco_i,
  input  logic [5:0]  prop_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] divr_o,
  output logic [31:0] aux_o,
  output logic        ref_en_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int SETTLE_CYC = SETTLE_REF * REF_RATIO;
  localparam int UPD_CYC    = UPD_REF * REF_RATIO;
  localparam int MAX_A      = (SEL_CYC > SHC_CYC) ? SEL_CYC : SHC_CYC;
  localparam int MAX_B      = (SETTLE_CYC > UPD_CYC) ? SETTLE_CYC : UPD_CYC;
  localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW         = $clog2(MAX_CYC) + 1;

  pll_op_t       op_enc;
  logic [CW-1:0] count;
  logic restart, cap, ld_sel, ld_shc, ld_gen, ld_prog;
  logic set_upd, clr_upd, ld_zero;

  // Encode operands into field codes before latching
  always_comb begin
    op_enc.cfg_rng = cfg_range(cfgclk_mhz_i);
    op_enc.hs_rng  = hs_range_i;
    op_enc.m_code  = mult_i - 10'd2;
    op_enc.n_code  = 4'(div_i - 5'd1);
    op_enc.vco     = vco_i;
    op_enc.prop    = prop_i;
  end

  pllprog_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .count   (count)
  );

  pllprog_fsm #(
    .SEL_CYC    (SEL_CYC),
    .SHC_CYC    (SHC_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .UPD_CYC    (UPD_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .pwr_off (pwr_off_i),
    .count   (count),
    .restart (restart),
    .cap     (cap),
    .ld_sel  (ld_sel),
    .ld_shc  (ld_shc),
    .ld_gen  (ld_gen),
    .ld_prog (ld_prog),
    .set_upd (set_upd),
    .clr_upd (clr_upd),
    .ld_zero (ld_zero),
    .busy    (busy_o),
    .done    (done_o)
  );

  pllprog_image u_image (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_in   (op_enc),
    .cap     (cap),
    .ld_sel  (ld_sel),
    .ld_shc  (ld_shc),
    .ld_gen  (ld_gen),
    .ld_prog (ld_prog),
    .set_upd (set_upd),
    .clr_upd (clr_upd),
    .ld_zero (ld_zero),
    .ctrl    (ctrl_o),
    .divr    (divr_o),
    .aux     (aux_o),
    .ref_en  (ref_en_o)
  );
endmodule

// File: rtl/pllprog_chk.sv
module pllprog_chk #(
  parameter int SHC_CYC    = 2,
  parameter int SETTLE_CYC = 20,
  parameter int UPD_CYC    = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_off_i,
  input logic [31:0] ctrl_o,
  input logic [31:0] divr_o,
  input logic [31:0] aux_o,
  input logic        ref_en_o,
  input logic        busy_o,
  input logic        done_o
);
  logic [15:0] ref_cnt, shc_cnt, upd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      shc_cnt <= '0;
      upd_cnt <= '0;
    end else begin
      ref_cnt <= !ref_en_o  ? '0 : (ref_cnt == 16'hFFFF ? ref_cnt : ref_cnt + 1'b1);
      shc_cnt <= !ctrl_o[18] ? '0 : (shc_cnt == 16'hFFFF ? shc_cnt : shc_cnt + 1'b1);
      upd_cnt <= !ctrl_o[17] ? '0 : (upd_cnt == 16'hFFFF ? upd_cnt : upd_cnt + 1'b1);
    end
  end

  assert_start_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (ctrl_o == 32'h40) && !ref_en_o);

  assert_shadow_with_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[18] |-> (ctrl_o[7:6] == 2'd1) && !ref_en_o);

  assert_shadow_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_o[18]) && ctrl_o[7:6] == 2'd1) |-> (shc_cnt >= 16'(SHC_CYC)));

  assert_settle_before_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[17]) |-> ref_en_o && (ref_cnt >= 16'(SETTLE_CYC)));

  assert_update_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_o[17]) && ref_en_o) |-> (upd_cnt >= 16'(UPD_CYC)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);

  assert_done_after_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_o[17]) && ref_en_o |=> done_o);

  assert_power_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_i |=> (ctrl_o == 32'd0) && (divr_o == 32'd0) && (aux_o == 32'd0)
                  && !ref_en_o && !busy_o && !done_o);
endmodule

bind pllprog_seq pllprog_chk #(
  .SHC_CYC    (SHC_CYC),
  .SETTLE_CYC (SETTLE_REF * REF_RATIO),
  .UPD_CYC    (UPD_REF * REF_RATIO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_off_i (pwr_off_i),
  .ctrl_o    (ctrl_o),
  .divr_o    (divr_o),
  .aux_o     (aux_o),
  .ref_en_o  (ref_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/sim_pllprog_seq.sv
module sim_pllprog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_CYC = 4, SHC_CYC = 2, SETTLE_REF = 10, UPD_REF = 4, REF_RATIO = 2;
  localparam int SETTLE = SETTLE_REF * REF_RATIO;
  localparam int UPD    = UPD_REF * REF_RATIO;
  localparam int LAT    = SEL_CYC + SHC_CYC + 1 + SETTLE + UPD + 1;
  localparam logic [31:0] AUX = 32'h41;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, pwr_off_i = 1'b0;
  logic [7:0] cfgclk_mhz_i = '0;
  logic [6:0] hs_range_i = '0;
  logic [9:0] mult_i = '0;
  logic [4:0] div_i = '0;
  logic [5:0] vco_i = '0, prop_i = '0;
  logic [31:0] ctrl_o, divr_o, aux_o;
  logic ref_en_o, busy_o, done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllprog_seq #(.SEL_CYC(SEL_CYC), .SHC_CYC(SHC_CYC), .SETTLE_REF(SETTLE_REF),
                .UPD_REF(UPD_REF), .REF_RATIO(REF_RATIO)) u0 (.*);

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [96:0] img;
    int          gap;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] exp_div = '0, exp_aux = '0;

  task automatic push(input logic [31:0] c, d, a, input logic r, input int gap, input string tag);
    exp_t e;
    e.img = {c, d, a, r};
    e.gap = gap;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: every change of the images is matched against the queue
  bit mon_on = 1'b0;
  int cyc = 0, last_chg = 0;
  logic [96:0] prev = '0;
  always @(negedge clk) begin
    if (mon_on) begin
      logic [96:0] cur;
      cyc++;
      cur = {ctrl_o, divr_o, aux_o, ref_en_o};
      if (cur != prev) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected image change", 128'(cur), 128'(prev));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cur == e.img, {e.tag, " image value"}, 128'(cur), 128'(e.img));
          if (e.gap != 0)
            chk(cyc - last_chg == e.gap, {e.tag, " cycles since previous change"},
                128'(cyc - last_chg), 128'(e.gap));
        end
        last_chg = cyc;
        prev     = cur;
      end
    end
  end

  // One run; abort_k != 0 raises power-off at that cycle count (R10)
  task automatic run_seq(input int mhz, hs, m, n, vco, prop, input bit dbl, input int abort_k);
    logic [31:0] full, dv;
    int done_k = 0, done_cnt = 0;
    full = 32'h40 | 32'(((mhz - 17) * 4) & 63) | (32'(hs) << 8);
    dv   = 32'((m - 2) & 1023) | (32'((n - 1) & 15) << 10) | (32'(vco) << 14) | (32'(prop) << 20);
    push(32'h40, exp_div, exp_aux, 1'b0, 0, "R2");
    push(32'h40040, exp_div, exp_aux, 1'b0, SEL_CYC, "R3");
    push(32'h40, exp_div, exp_aux, 1'b0, SHC_CYC, "R3");
    push(full, dv, AUX, 1'b1, 1, "R4");
    if (abort_k == 0) begin
      push(full | 32'h20000, dv, AUX, 1'b1, SETTLE, "R5");
      push(full, dv, AUX, 1'b1, UPD, "R6");
      exp_div = dv;
      exp_aux = AUX;
    end else begin
      push(32'd0, 32'd0, 32'd0, 1'b0, abort_k + 1 - (SEL_CYC + SHC_CYC + 1), "R10");
      exp_div = '0;
      exp_aux = '0;
    end
    @(negedge clk);
    cfgclk_mhz_i = 8'(mhz); hs_range_i = 7'(hs); mult_i = 10'(m);
    div_i = 5'(n); vco_i = 6'(vco); prop_i = 6'(prop);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R9: operands change during the run
    cfgclk_mhz_i = 8'd50; hs_range_i = 7'h7f; mult_i = 10'd300; div_i = 5'd7;
    vco_i = 6'h3f; prop_i = 6'h3f;
    for (int k = 1; k <= LAT + 12; k++) begin
      @(negedge clk);
      if (k == 1) chk(busy_o == 1'b1, "R7 busy after start", 128'(busy_o), 128'(1));
      if (done_o) begin
        done_cnt++;
        if (done_k == 0) done_k = k;
        chk(busy_o == 1'b0, "R7 busy low with done", 128'(busy_o), 128'(0));
      end
      if (dbl && k == 5) begin
        chk(busy_o == 1'b1, "R8 busy at second start", 128'(busy_o), 128'(1));
        start_i = 1'b1;
      end
      if (dbl && k == 6) start_i = 1'b0;
      if (abort_k != 0 && k == abort_k) pwr_off_i = 1'b1;
      if (abort_k != 0 && k == abort_k + 1) pwr_off_i = 1'b0;
    end
    if (abort_k == 0) begin
      chk(done_k == LAT, "R7 done cycle after start", 128'(done_k), 128'(LAT));
      chk(done_cnt == 1, "R8 single done per run", 128'(done_cnt), 128'(1));
    end else begin
      chk(done_cnt == 0, "R10 no done after abort", 128'(done_cnt), 128'(0));
      chk(busy_o == 1'b0, "R10 idle after abort", 128'(busy_o), 128'(0));
    end
    chk(q.size() == 0, "R8 all expected changes seen", 128'(q.size()), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    total++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ctrl_o, divr_o, aux_o} == 96'd0, "R1 images zero", 128'({ctrl_o, divr_o, aux_o}), 128'(0));
    chk({ref_en_o, busy_o, done_o} == 3'b000, "R1 status low", 128'({ref_en_o, busy_o, done_o}), 128'(0));
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);

    run_seq(24, 'h2a, 250, 3, 'h0f, 'h0d, 1'b1, 0);   // R8 second start mid-run
    run_seq(20, 'h49, 625, 16, 'h01, 'h0e, 1'b0, 0);  // max M and N
    run_seq(33, 'h05, 64, 1, 'h3f, 'h0d, 1'b0, 9);    // R10 abort in settle; range wraps to 0

    // R10: power-off beats simultaneous start (images already zero, so none may change)
    @(negedge clk);
    start_i = 1'b1; pwr_off_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; pwr_off_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R10 power-off wins over start", 128'(busy_o), 128'(0));

    run_seq(32, 'h3b, 100, 2, 'h07, 'h0d, 1'b0, 0);   // range field 60

    // R10: power-off after a completed run
    push(32'd0, 32'd0, 32'd0, 1'b0, 0, "R10");
    @(negedge clk);
    pwr_off_i = 1'b1;
    @(negedge clk);
    pwr_off_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10 zeroed after done", 128'(q.size()), 128'(0));
    chk(ref_en_o == 1'b0, "R10 reference enable dropped", 128'(ref_en_o), 128'(0));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule